// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block carries a processor core from an accepted interrupt request to the first fetch of the handler. When a request arrives above the current priority mask (or at the non-maskable level 7), the block captures the status register, program counter and both supervisor stack pointers. It then runs an interrupt-acknowledge handshake that drives the level being serviced. From the response it resolves a vector number in one of three ways: the byte the device supplies, an autovector derived from the level, or the spurious vector after a bus error.

The block then writes the exception frame as 16-bit halfwords through a handshaked write port. If the master-stack bit was set, it writes a second, throwaway frame on the interrupt stack. Next it reads the handler address from the vector table through a handshaked read port. It presents the new PC, status register and stack pointers together with a one-cycle pulse that lets handler prefetch begin.

Status-register bit positions used throughout: trace field bits 15:14, supervisor bit 13, master bit 12, priority mask bits 10:8.

Top module: `irq_entry_seq`

## Requirements
- R1: When idle, a request is accepted if its level is nonzero and either exceeds the mask field of `cur_sr` or equals 7. `busy` rises on the following cycle and stays high until the cycle in which `handler_go` pulses, when it is low. A request that fails the rule leaves `busy`, `iack_req`, `mw_req` and `mr_req` low.
- R2: While `iack_req` is high, `iack_lvl` carries the accepted level. At all other times it is zero.
- R3: On an acknowledge with neither autovector nor bus error, the vector number is `iack_data`. The value 15 is treated like any other vector.
- R4: On an autovector response without a bus error, the vector number is 24 plus the level, and `iack_data` is ignored.
- R5: On a bus-error response, the vector number is 24, whatever the other response inputs show.
- R6: The main frame is four halfword writes, issued in descending order from SP-2 to SP-8, where SP is `cur_msp` if the master bit is set and `cur_isp` otherwise. The writes are: the format word (format 0 in bits 15:12, vector number times 4 in bits 11:0) at SP-2, PC[15:0] at SP-4, PC[31:16] at SP-6, and the unmodified captured status register at SP-8.
- R7: If the master bit was set, a second set of four writes follows on `cur_isp`, using the same layout, PC and offset. This frame carries format 1 and the handler status image described in R10.
- R8: `new_isp` equals `cur_isp` minus 8. `new_msp` equals `cur_msp` minus 8 when the master bit was set, and `cur_msp` otherwise.
- R9: The vector-table read uses address `vbr` plus the vector number times 4. `new_pc` is the returned data, and `handler_go` pulses for one cycle after the read completes.
- R10: `new_sr` is the captured status register with bits 15:14 cleared, bit 13 set, bit 12 cleared and bits 10:8 set to the level. All other bits are kept.
- R11: A pending write or read keeps its request, address and data stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request present |
| irq_lvl | input | 3 | Requested level |
| cur_sr | input | 16 | Current status register |
| cur_pc | input | 32 | Address of the next instruction |
| cur_isp | input | 32 | Interrupt stack pointer |
| cur_msp | input | 32 | Master stack pointer |
| vbr | input | 32 | Vector table base |
| busy | output | 1 | Entry sequence in progress |
| iack_req | output | 1 | Acknowledge cycle request |
| iack_lvl | output | 3 | Level driven during acknowledge |
| iack_ack | input | 1 | Device supplied a vector |
| iack_avec | input | 1 | Use autovector |
| iack_berr | input | 1 | Bus error on acknowledge |
| iack_data | input | 8 | Device vector byte |
| mw_req | output | 1 | Halfword write request |
| mw_addr | output | 32 | Write address |
| mw_data | output | 16 | Write data |
| mw_ack | input | 1 | Write accepted |
| mr_req | output | 1 | Vector table read request |
| mr_addr | output | 32 | Read address |
| mr_data | input | 32 | Read data |
| mr_ack | input | 1 | Read data valid |
| handler_go | output | 1 | One-cycle pulse: handler fetch may start |
| new_pc | output | 32 | Handler address |
| new_sr | output | 16 | Status register for the handler |
| new_isp | output | 32 | Updated interrupt stack pointer |
| new_msp | output | 32 | Updated master stack pointer |

## Verification
The assertions assume that the stack pointers are even. They also assume that every response or acknowledge input is a single-cycle pulse, raised only while the matching request is high. The bench responders follow these rules. They sample at the falling edge and raise an acknowledge only when they see a pending request, then drop it on the next falling edge. The bench chooses only even stack pointers. One scenario delays write acknowledges for several cycles and watches the held address and data.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int SR_W    = 16;
  localparam int VEC_W   = 8;
  localparam int LVL_W   = 3;
  localparam int OFF_W   = 12;
  localparam int FMT_W   = 4;

  localparam int SRB_TRC_HI = 15;
  localparam int SRB_TRC_LO = 14;
  localparam int SRB_SUP    = 13;
  localparam int SRB_MST    = 12;
  localparam int SRB_MSK_HI = 10;
  localparam int SRB_MSK_LO = 8;

  localparam logic [VEC_W-1:0] VEC_SPURIOUS = 8'd24;
  localparam logic [FMT_W-1:0] FMT_NORMAL   = 4'h0;
  localparam logic [FMT_W-1:0] FMT_THROW    = 4'h1;

  typedef enum logic [1:0] {ST_IDLE, ST_IACK, ST_PUSH, ST_FETCH} seq_state_t;
  typedef enum logic [1:0] {RSP_NONE, RSP_DEVICE, RSP_AUTO, RSP_SPUR} iack_rsp_t;

  function automatic logic [LVL_W-1:0] sr_mask(input logic [SR_W-1:0] sr);
    return sr[SRB_MSK_HI:SRB_MSK_LO];
  endfunction

  function automatic logic accept_ok(input logic [LVL_W-1:0] lvl,
                                     input logic [LVL_W-1:0] mask);
    return (lvl != '0) && ((lvl > mask) || (lvl == 3'd7));
  endfunction

  function automatic logic [VEC_W-1:0] auto_vec(input logic [LVL_W-1:0] lvl);
    return VEC_SPURIOUS + VEC_W'(lvl);
  endfunction

  function automatic logic [OFF_W-1:0] vec_offset(input logic [VEC_W-1:0] vec);
    return {2'b00, vec, 2'b00};
  endfunction

  function automatic logic [SR_W-1:0] fmt_word(input logic [FMT_W-1:0] fmt,
                                                input logic [OFF_W-1:0] off);
    return {fmt, off};
  endfunction

  function automatic logic [SR_W-1:0] handler_sr(input logic [SR_W-1:0] sr,
                                                  input logic [LVL_W-1:0] lvl);
    logic [SR_W-1:0] r;
    r = sr;
    r[SRB_TRC_HI] = 1'b0;
    r[SRB_TRC_LO] = 1'b0;
    r[SRB_SUP]    = 1'b1;
    r[SRB_MST]    = 1'b0;
    r[SRB_MSK_HI:SRB_MSK_LO] = lvl;
    return r;
  endfunction
endpackage

// File: rtl/irq_vec_resolve.sv
module irq_vec_resolve
  import irq_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             listen,
  input  logic [LVL_W-1:0] lvl,
  input  logic             rsp_ack,
  input  logic             rsp_avec,
  input  logic             rsp_berr,
  input  logic [VEC_W-1:0] rsp_data,
  output logic             resp_seen,
  output logic [VEC_W-1:0] vec_q
);
  iack_rsp_t        kind;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    kind  = RSP_NONE;
    vec_d = vec_q;
    if (listen) begin
      if (rsp_berr) begin
        kind  = RSP_SPUR;
        vec_d = VEC_SPURIOUS;
      end else if (rsp_avec) begin
        kind  = RSP_AUTO;
        vec_d = auto_vec(lvl);
      end else if (rsp_ack) begin
        kind  = RSP_DEVICE;
        vec_d = rsp_data;
      end
    end
  end

  assign resp_seen = (kind != RSP_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) vec_q <= '0;
    else        vec_q <= vec_d;
  end

  // R5: bus error always yields the spurious vector
  p_spurious_vec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    listen && rsp_berr |=> vec_q == 8'd24);

  // R4: autovector is 24 plus the level, data byte ignored
  p_auto_vec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    listen && rsp_avec && !rsp_berr |=> vec_q == 8'd24 + {5'd0, $past(lvl)});

  // R3: plain acknowledge takes the device byte
  p_device_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    listen && rsp_ack && !rsp_avec && !rsp_berr |=> vec_q == $past(rsp_data));
endmodule

// File: rtl/irq_frame_push.sv
module irq_frame_push
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              two_frames,
  input  logic [ADDR_W-1:0] sp_first,
  input  logic [ADDR_W-1:0] sp_second,
  input  logic [SR_W-1:0]   sr_saved,
  input  logic [SR_W-1:0]   sr_throw,
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  vec_off,
  output logic              mw_req,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [SR_W-1:0]   mw_data,
  input  logic              mw_ack,
  output logic              fin
);
  localparam int WORDS_PER_FRAME = 4;
  localparam int IDX_W           = $clog2(2 * WORDS_PER_FRAME);
  localparam int WSEL_W          = $clog2(WORDS_PER_FRAME);

  logic              active;
  logic [IDX_W-1:0]  idx;
  logic              last;
  logic              sel_second;
  logic [WSEL_W-1:0] word;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] step;

  assign sel_second = idx[IDX_W-1];
  assign word       = idx[WSEL_W-1:0];
  assign last       = two_frames ? (idx == IDX_W'(2 * WORDS_PER_FRAME - 1))
                                 : (idx == IDX_W'(WORDS_PER_FRAME - 1));
  assign base       = sel_second ? sp_second : sp_first;
  assign step       = ADDR_W'({word, 1'b0}) + ADDR_W'(2);

  assign mw_req  = active;
  assign mw_addr = base - step;

  always_comb begin
    case (word)
      2'd0:    mw_data = fmt_word(sel_second ? FMT_THROW : FMT_NORMAL, vec_off);
      2'd1:    mw_data = SR_W'(pc);
      2'd2:    mw_data = SR_W'(pc >> 16);
      default: mw_data = sel_second ? sr_throw : sr_saved;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= active && mw_ack && last;
      if (start) begin
        active <= 1'b1;
        idx    <= '0;
      end else if (active && mw_ack) begin
        if (last) active <= 1'b0;
        else      idx    <= idx + 1'b1;
      end
    end
  end

  // R11: pending write holds address and data
  p_write_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mw_req && !mw_ack |=> mw_req && $stable(mw_addr) && $stable(mw_data));

  // R6: halfword writes land on even addresses
  p_even_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mw_req |-> !mw_addr[0]);

  // R6: completion pulse is a single cycle
  p_fin_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  input  logic [2:0]        irq_lvl,
  input  logic [15:0]       cur_sr,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] cur_isp,
  input  logic [ADDR_W-1:0] cur_msp,
  input  logic [ADDR_W-1:0] vbr,
  output logic              busy,
  output logic              iack_req,
  output logic [2:0]        iack_lvl,
  input  logic              iack_ack,
  input  logic              iack_avec,
  input  logic              iack_berr,
  input  logic [7:0]        iack_data,
  output logic              mw_req,
  output logic [ADDR_W-1:0] mw_addr,
  output logic [15:0]       mw_data,
  input  logic              mw_ack,
  output logic              mr_req,
  output logic [ADDR_W-1:0] mr_addr,
  input  logic [ADDR_W-1:0] mr_data,
  input  logic              mr_ack,
  output logic              handler_go,
  output logic [ADDR_W-1:0] new_pc,
  output logic [15:0]       new_sr,
  output logic [ADDR_W-1:0] new_isp,
  output logic [ADDR_W-1:0] new_msp
);
  localparam int FRAME_BYTES = 8;

  seq_state_t        st;
  logic [LVL_W-1:0]  lvl_q;
  logic [SR_W-1:0]   sr_q;
  logic [ADDR_W-1:0] pc_q, isp_q, msp_q, vbr_q;

  logic              accept_now;
  logic              resp_seen;
  logic [VEC_W-1:0]  vec_q;
  logic              push_start;
  logic              push_fin;
  logic              m_set;
  logic [ADDR_W-1:0] sp_first;
  logic [SR_W-1:0]   sr_force;

  assign accept_now = (st == ST_IDLE) && irq_req && accept_ok(irq_lvl, sr_mask(cur_sr));
  assign busy       = (st != ST_IDLE);
  assign iack_req   = (st == ST_IACK);
  assign iack_lvl   = iack_req ? lvl_q : '0;
  assign push_start = iack_req && resp_seen;
  assign m_set      = sr_q[SRB_MST];
  assign sp_first   = m_set ? msp_q : isp_q;
  assign sr_force   = handler_sr(sr_q, lvl_q);
  assign mr_req     = (st == ST_FETCH);
  assign mr_addr    = vbr_q + ADDR_W'(vec_offset(vec_q));

  irq_vec_resolve u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .listen    (iack_req),
    .lvl       (lvl_q),
    .rsp_ack   (iack_ack),
    .rsp_avec  (iack_avec),
    .rsp_berr  (iack_berr),
    .rsp_data  (iack_data),
    .resp_seen (resp_seen),
    .vec_q     (vec_q)
  );

  irq_frame_push #(.ADDR_W(ADDR_W)) u_push (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (push_start),
    .two_frames (m_set),
    .sp_first   (sp_first),
    .sp_second  (isp_q),
    .sr_saved   (sr_q),
    .sr_throw   (sr_force),
    .pc         (pc_q),
    .vec_off    (vec_offset(vec_q)),
    .mw_req     (mw_req),
    .mw_addr    (mw_addr),
    .mw_data    (mw_data),
    .mw_ack     (mw_ack),
    .fin        (push_fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      lvl_q      <= '0;
      sr_q       <= '0;
      pc_q       <= '0;
      isp_q      <= '0;
      msp_q      <= '0;
      vbr_q      <= '0;
      handler_go <= 1'b0;
      new_pc     <= '0;
      new_sr     <= '0;
      new_isp    <= '0;
      new_msp    <= '0;
    end else begin
      handler_go <= 1'b0;
      case (st)
        ST_IDLE: if (accept_now) begin
          lvl_q <= irq_lvl;
          sr_q  <= cur_sr;
          pc_q  <= cur_pc;
          isp_q <= cur_isp;
          msp_q <= cur_msp;
          vbr_q <= vbr;
          st    <= ST_IACK;
        end
        ST_IACK:  if (resp_seen) st <= ST_PUSH;
        ST_PUSH:  if (push_fin)  st <= ST_FETCH;
        default: if (mr_ack) begin
          new_pc     <= mr_data;
          new_sr     <= sr_force;
          new_isp    <= isp_q - ADDR_W'(FRAME_BYTES);
          new_msp    <= m_set ? msp_q - ADDR_W'(FRAME_BYTES) : msp_q;
          handler_go <= 1'b1;
          st         <= ST_IDLE;
        end
      endcase
    end
  end

  // R1: an entry only starts for a level above the mask, or level 7
  p_accept_rule_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(irq_lvl) == 3'd7) || ($past(irq_lvl) > $past(cur_sr[10:8])));

  // R1: no bus activity outside an entry
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !iack_req && !mw_req && !mr_req);

  // R2: acknowledge level nonzero and steady while requested
  p_iack_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req |-> iack_lvl != 3'd0);
  p_iack_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req && $past(iack_req) |-> $stable(iack_lvl));

  // R9: handler start follows a completed table read
  p_go_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    handler_go |-> $past(mr_req && mr_ack) && !busy);

  // R10: handler status register is supervisor, master clear, no trace
  p_final_sr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    handler_go |-> new_sr[13] && !new_sr[12] && (new_sr[15:14] == 2'b00));

  // R11: pending table read holds its address
  p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mr_req && !mr_ack |=> mr_req && $stable(mr_addr));
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_req;
  logic [2:0]  irq_lvl;
  logic [15:0] cur_sr;
  logic [31:0] cur_pc, cur_isp, cur_msp, vbr;
  logic        busy, iack_req;
  logic [2:0]  iack_lvl;
  logic        iack_ack, iack_avec, iack_berr;
  logic [7:0]  iack_data;
  logic        mw_req;
  logic [31:0] mw_addr;
  logic [15:0] mw_data;
  logic        mw_ack;
  logic        mr_req;
  logic [31:0] mr_addr, mr_data;
  logic        mr_ack;
  logic        handler_go;
  logic [31:0] new_pc, new_isp, new_msp;
  logic [15:0] new_sr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  irq_entry_seq dut (.*);

  function automatic logic [31:0] tbl(input logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // acknowledge responder: 0 device, 1 autovector (ack also high), 2 bus error, 3 bus error with autovector
  int         iack_mode = 0;
  logic [7:0] iack_byte = 8'h00;
  logic [2:0] seen_tm   = 3'd0;
  initial begin
    iack_ack = 0; iack_avec = 0; iack_berr = 0; iack_data = 8'h00;
    forever begin
      @(negedge clk);
      if (iack_ack || iack_avec || iack_berr) begin
        iack_ack = 0; iack_avec = 0; iack_berr = 0;
      end else if (iack_req) begin
        seen_tm   = iack_lvl;
        iack_data = iack_byte;
        case (iack_mode)
          0:       iack_ack = 1;
          1:       begin iack_avec = 1; iack_ack = 1; end
          2:       iack_berr = 1;
          default: begin iack_berr = 1; iack_avec = 1; end
        endcase
      end
    end
  end

  // write responder with programmable latency
  logic [31:0] wa [0:127];
  logic [15:0] wd [0:127];
  int          wn = 0;
  int          wr_lat = 0;
  int          hold_err = 0;
  int          wait_cnt = 0;
  logic [31:0] cap_a;
  logic [15:0] cap_d;
  initial begin
    mw_ack = 0;
    forever begin
      @(negedge clk);
      if (mw_ack) mw_ack = 0;
      else if (mw_req) begin
        if (wait_cnt == 0) begin cap_a = mw_addr; cap_d = mw_data; end
        else if (mw_addr != cap_a || mw_data != cap_d) hold_err++;
        if (wait_cnt >= wr_lat) begin
          wa[wn] = cap_a; wd[wn] = cap_d; wn++;
          mw_ack = 1; wait_cnt = 0;
        end else wait_cnt++;
      end
    end
  end

  // table read responder
  logic [31:0] rd_addr = 32'h0;
  initial begin
    mr_ack = 0; mr_data = 32'h0;
    forever begin
      @(negedge clk);
      if (mr_ack) mr_ack = 0;
      else if (mr_req) begin
        rd_addr = mr_addr;
        mr_data = tbl(mr_addr);
        mr_ack  = 1;
      end
    end
  end

  task automatic run_case(input logic [2:0] lvl, input logic [15:0] sr, input logic [31:0] pc,
                          input logic [31:0] isp, input logic [31:0] msp, input logic [31:0] vb,
                          input int mode, input logic [7:0] byt, input logic [7:0] exp_vec,
                          input string vtag);
    int          w0;
    bit          got;
    bit          m;
    int          nf;
    logic [11:0] off;
    logic [15:0] hsr;
    logic [31:0] ea [0:7];
    logic [15:0] ed [0:7];
    int          bad;
    w0 = wn;
    iack_mode = mode; iack_byte = byt;
    @(negedge clk);
    irq_lvl = lvl; cur_sr = sr; cur_pc = pc; cur_isp = isp; cur_msp = msp; vbr = vb; irq_req = 1;
    @(negedge clk);
    irq_req = 0;
    chk(busy == 1'b1, "R1 busy after accept", 32'(busy), 32'd1);
    got = 0;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      if (handler_go) got = 1;
    end
    chk(got, "R9 handler_go seen", 32'(got), 32'd1);
    chk(busy == 1'b0, "R1 busy low with handler_go", 32'(busy), 32'd0);
    m   = sr[12];
    nf  = m ? 2 : 1;
    off = 12'(exp_vec) * 12'd4;
    hsr = (sr & ~16'hD700) | 16'h2000 | (16'(lvl) << 8);
    for (int f = 0; f < nf; f++) begin
      logic [31:0] b;
      b = (f == 0) ? (m ? msp : isp) : isp;
      ea[f*4+0] = b - 2; ed[f*4+0] = (16'(f) << 12) | 16'(off);
      ea[f*4+1] = b - 4; ed[f*4+1] = pc[15:0];
      ea[f*4+2] = b - 6; ed[f*4+2] = pc[31:16];
      ea[f*4+3] = b - 8; ed[f*4+3] = (f == 0) ? sr : hsr;
    end
    chk(seen_tm == lvl, "R2 iack_lvl during acknowledge", 32'(seen_tm), 32'(lvl));
    chk(iack_lvl == 3'd0, "R2 iack_lvl zero when idle", 32'(iack_lvl), 32'd0);
    chk(wd[w0] == ed[0], vtag, 32'(wd[w0]), 32'(ed[0]));
    chk((wn - w0) == nf * 4, m ? "R7 write count" : "R6 write count", 32'(wn - w0), 32'(nf * 4));
    bad = 0;
    for (int i = 0; i < 4; i++) if (wa[w0+i] != ea[i] || wd[w0+i] != ed[i]) bad++;
    chk(bad == 0, "R6 main frame contents", 32'(bad), 32'd0);
    if (m) begin
      bad = 0;
      for (int i = 4; i < 8; i++) if (wa[w0+i] != ea[i] || wd[w0+i] != ed[i]) bad++;
      chk(bad == 0, "R7 throwaway frame contents", 32'(bad), 32'd0);
    end
    chk(rd_addr == vb + 32'(off), "R9 table address", rd_addr, vb + 32'(off));
    chk(new_pc == tbl(vb + 32'(off)), "R9 new_pc", new_pc, tbl(vb + 32'(off)));
    chk(new_sr == hsr, "R10 new_sr", 32'(new_sr), 32'(hsr));
    chk(new_isp == isp - 8, "R8 new_isp", new_isp, isp - 8);
    chk(new_msp == (m ? msp - 8 : msp), "R8 new_msp", new_msp, m ? msp - 8 : msp);
  endtask

  task automatic t_reset;
    chk(!busy && !iack_req && !mw_req && !mr_req && !handler_go, "R1 reset idle",
        {27'd0, busy, iack_req, mw_req, mr_req, handler_go}, 32'd0);
  endtask

  task automatic t_device;
    run_case(3'd3, 16'h2000, 32'h0000_1234, 32'h0000_8000, 32'h0000_9000, 32'h0000_0400,
             0, 8'h40, 8'h40, "R3 device vector 0x40");
  endtask

  task automatic t_uninit;
    run_case(3'd4, 16'h0100, 32'hABCD_0010, 32'h0001_0000, 32'h0002_0000, 32'h0000_0000,
             0, 8'd15, 8'd15, "R3 device vector 15");
  endtask

  task automatic t_autovec;
    run_case(3'd5, 16'h0000, 32'h0040_0002, 32'h0000_7F00, 32'h0000_6F00, 32'h1000_0000,
             1, 8'h99, 8'd29, "R4 autovector level 5");
  endtask

  task automatic t_spurious;
    run_case(3'd2, 16'h0000, 32'h0000_0100, 32'h0000_5000, 32'h0000_4000, 32'h0000_0800,
             3, 8'h77, 8'd24, "R5 spurious vector");
  endtask

  task automatic t_master;
    run_case(3'd6, 16'h9203, 32'h1122_3344, 32'h0000_A000, 32'h0000_C000, 32'h0000_2000,
             0, 8'h50, 8'h50, "R3 device vector with master set");
  endtask

  task automatic t_level7_slow;
    wr_lat = 3;
    hold_err = 0;
    run_case(3'd7, 16'h3700, 32'h0BAD_F00C, 32'h0000_3000, 32'h0000_3800, 32'h0000_0000,
             1, 8'h00, 8'd31, "R4 autovector level 7");
    chk(hold_err == 0, "R11 write held until acknowledged", 32'(hold_err), 32'd0);
    wr_lat = 0;
  endtask

  task automatic t_reject;
    for (int k = 0; k < 2; k++) begin
      bit seen;
      @(negedge clk);
      cur_sr = 16'h0500; irq_lvl = (k == 0) ? 3'd3 : 3'd5; irq_req = 1;
      seen = 0;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        if (busy || iack_req || mw_req || mr_req) seen = 1;
      end
      irq_req = 0;
      chk(!seen, "R1 masked request ignored", 32'(seen), 32'd0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; irq_req = 0; irq_lvl = 0; cur_sr = 0; cur_pc = 0;
    cur_isp = 0; cur_msp = 0; vbr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_device();
    t_uninit();
    t_autovec();
    t_spurious();
    t_master();
    t_reject();
    t_level7_slow();
    repeat (4) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule